// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of a byte-wide parallel NOR-style flash and turns single local requests into complete flash operations. A requester presents one of three operations (byte program, sector erase or whole-chip erase) with a target address and data byte. The sequencer then writes the unlock command bytes one bus write at a time, with the chip-enable, output-enable and write-enable strobes ordered correctly and their widths counted in clock cycles from parameters.

Once the last command byte is written, the sequencer polls the flash. It repeatedly reads the target address and compares bit 7 of the returned byte against the value expected on completion. For a program this is bit 7 of the written byte. For an erase it is 1, because erased bytes read back as all ones. A poll limit set by a parameter bounds the wait. The requester sees a busy level for the whole operation, then a one-cycle done pulse or a one-cycle timeout pulse.

The flash data bus is split into an output byte, an input byte and an output-enable. The pad ring joins them into the bidirectional pins.

Top module: `flash_cmd_seq`

## Requirements
- R1: A program request (req_op = 0) produces exactly four bus writes, as address/data: UNLOCK_A/AAh, UNLOCK_B/55h, UNLOCK_A/A0h, then the target address with the request data.
- R2: A sector erase request (req_op = 1) produces exactly six bus writes: UNLOCK_A/AAh, UNLOCK_B/55h, UNLOCK_A/80h, UNLOCK_A/AAh, UNLOCK_B/55h, then the target (sector) address with 30h.
- R3: A chip erase request (req_op = 2) produces the same first five writes as R2, followed by UNLOCK_A/10h.
- R4: The write strobe is low only while chip enable is low, output enable is high and the host drives the data bus.
- R5: Address and data do not change at the cycle where the write strobe rises.
- R6: Each write strobe low pulse lasts exactly T_WP clock cycles. Between two writes, the strobe stays high for at least T_WPH cycles.
- R7: A poll read holds chip enable and output enable low for exactly T_ACC cycles, with the write strobe high and the data bus released.
- R8: Every poll read of an operation uses the target address of that request.
- R9: After a program, the block keeps polling while the read bit 7 is the complement of request data bit 7. On the first read where bit 7 matches, it raises done for exactly one cycle.
- R10: After an erase, the block keeps polling while the read bit 7 is 0, and raises done on the first read where bit 7 is 1.
- R11: If MAX_POLLS reads pass without completion, the block raises timeout for one cycle instead of done. Done and timeout are never high together.
- R12: busy is high from the cycle after a request is accepted until the cycle in which done or timeout is high, where it is low. Requests presented while busy is high are ignored, and so is req_op = 3.
- R13: With P polls returning "not complete", done rises W*(T_WP+T_WPH+2) + (P+1)*(T_ACC+2) clock edges after the accepting edge, where W is 4 for a program and 6 for an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 ignored |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle poll-limit pulse |
| f_addr | output | AW | Flash address bus |
| f_dq_out | output | 8 | Data driven toward the flash |
| f_dq_oe | output | 1 | Host drives the data bus when high |
| f_dq_in | input | 8 | Data returned by the flash |
| f_ce_n | output | 1 | Flash chip enable, active low |
| f_oe_n | output | 1 | Flash output enable, active low |
| f_we_n | output | 1 | Flash write enable, active low |

## Verification
Each command write takes T_WP+T_WPH+2 cycles and each poll read takes T_ACC+2. A result therefore falls due a fixed number of edges after the accepting edge: done or timeout after the full R13 count, and busy one edge after acceptance. The bench counts rising edges from the accepting edge and samples every output at the following falling edge, so a result that arrives early or late by even one cycle changes the count it compares. Strobe widths are measured in simulation time between the strobe edges and compared against the parameter multiplied by the clock period.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_SECT = 2'd1,
      OP_CHIP = 2'd2,
      OP_NONE = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      BC_IDLE, BC_SETUP, BC_WLOW, BC_WHIGH, BC_READ, BC_RGAP
   } bc_state_e;

   typedef enum logic [1:0] {
      SQ_IDLE, SQ_CMD, SQ_POLL
   } sq_state_e;

   localparam logic [7:0] CODE_UNLK1 = 8'hAA;
   localparam logic [7:0] CODE_UNLK2 = 8'h55;
   localparam logic [7:0] CODE_PROG  = 8'hA0;
   localparam logic [7:0] CODE_ERASE = 8'h80;
   localparam logic [7:0] CODE_CHIP  = 8'h10;
   localparam logic [7:0] CODE_SECT  = 8'h30;
endpackage

// File: rtl/fseq_cmd_table.sv
module fseq_cmd_table
   import fseq_pkg::*;
#(
   parameter int AW       = 19,
   parameter int UNLOCK_A = 'h555,
   parameter int UNLOCK_B = 'hAAA
) (
   input  op_e           op,
   input  logic [2:0]    step,
   input  logic [AW-1:0] tgt_addr,
   input  logic [7:0]    tgt_data,
   output logic [AW-1:0] addr,
   output logic [7:0]    data,
   output logic          last
);
   localparam logic [AW-1:0] ADR_A = AW'(UNLOCK_A);
   localparam logic [AW-1:0] ADR_B = AW'(UNLOCK_B);

   always_comb begin
      addr = ADR_A;
      data = CODE_UNLK1;
      last = 1'b0;
      if (op == OP_PROG) begin
         case (step)
            3'd0: begin addr = ADR_A; data = CODE_UNLK1; end
            3'd1: begin addr = ADR_B; data = CODE_UNLK2; end
            3'd2: begin addr = ADR_A; data = CODE_PROG;  end
            default: begin addr = tgt_addr; data = tgt_data; last = 1'b1; end
         endcase
      end else begin
         case (step)
            3'd0: begin addr = ADR_A; data = CODE_UNLK1; end
            3'd1: begin addr = ADR_B; data = CODE_UNLK2; end
            3'd2: begin addr = ADR_A; data = CODE_ERASE; end
            3'd3: begin addr = ADR_A; data = CODE_UNLK1; end
            3'd4: begin addr = ADR_B; data = CODE_UNLK2; end
            default: begin
               last = 1'b1;
               if (op == OP_CHIP) begin
                  addr = ADR_A;
                  data = CODE_CHIP;
               end else begin
                  addr = tgt_addr;
                  data = CODE_SECT;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/fseq_bus_cycle.sv
module fseq_bus_cycle
   import fseq_pkg::*;
#(
   parameter int AW    = 19,
   parameter int T_WP  = 3,
   parameter int T_WPH = 2,
   parameter int T_ACC = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          rd,
   input  logic [AW-1:0] addr_i,
   input  logic [7:0]    data_i,
   output logic          idle_o,
   output logic          done_o,
   output logic [7:0]    rdata_o,
   output logic [AW-1:0] f_addr,
   output logic [7:0]    f_dq_out,
   output logic          f_dq_oe,
   input  logic [7:0]    f_dq_in,
   output logic          f_ce_n,
   output logic          f_oe_n,
   output logic          f_we_n
);
   localparam int TMAX = (T_WP > T_WPH) ? ((T_WP > T_ACC) ? T_WP : T_ACC)
                                        : ((T_WPH > T_ACC) ? T_WPH : T_ACC);
   localparam int CW = $clog2(TMAX + 1);

   bc_state_e      state;
   logic [CW-1:0]  cnt;
   logic [AW-1:0]  addr_q;
   logic [7:0]     data_q;
   logic [7:0]     rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= BC_IDLE;
         cnt     <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         rdata_q <= '0;
      end else begin
         case (state)
            BC_IDLE: if (start) begin
               addr_q <= addr_i;
               data_q <= data_i;
               if (rd) begin
                  state <= BC_READ;
                  cnt   <= CW'(T_ACC - 1);
               end else begin
                  state <= BC_SETUP;
               end
            end
            BC_SETUP: begin
               state <= BC_WLOW;
               cnt   <= CW'(T_WP - 1);
            end
            BC_WLOW: if (cnt == '0) begin
               state <= BC_WHIGH;
               cnt   <= CW'(T_WPH - 1);
            end else begin
               cnt <= cnt - 1'b1;
            end
            BC_WHIGH: if (cnt == '0) state <= BC_IDLE;
                      else cnt <= cnt - 1'b1;
            BC_READ: if (cnt == '0) begin
               rdata_q <= f_dq_in;
               state   <= BC_RGAP;
            end else begin
               cnt <= cnt - 1'b1;
            end
            default: state <= BC_IDLE;
         endcase
      end
   end

   assign idle_o   = (state == BC_IDLE);
   assign done_o   = ((state == BC_WHIGH) && (cnt == '0)) || (state == BC_RGAP);
   assign rdata_o  = rdata_q;
   assign f_addr   = addr_q;
   assign f_dq_out = data_q;
   assign f_dq_oe  = (state == BC_SETUP) || (state == BC_WLOW) || (state == BC_WHIGH);
   assign f_ce_n   = !((state == BC_SETUP) || (state == BC_WLOW) || (state == BC_READ));
   assign f_oe_n   = (state != BC_READ);
   assign f_we_n   = (state != BC_WLOW);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import fseq_pkg::*;
#(
   parameter int AW        = 19,
   parameter int T_WP      = 3,
   parameter int T_WPH     = 2,
   parameter int T_ACC     = 3,
   parameter int MAX_POLLS = 1024,
   parameter int UNLOCK_A  = 'h555,
   parameter int UNLOCK_B  = 'hAAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_data,
   output logic          busy,
   output logic          done,
   output logic          timeout,
   output logic [AW-1:0] f_addr,
   output logic [7:0]    f_dq_out,
   output logic          f_dq_oe,
   input  logic [7:0]    f_dq_in,
   output logic          f_ce_n,
   output logic          f_oe_n,
   output logic          f_we_n
);
   localparam int PCW = $clog2(MAX_POLLS + 1);

   generate
      if (AW < 12) begin : g_bad_aw
         $error("flash_cmd_seq: AW must hold the unlock addresses");
      end
      if (T_WP < 1 || T_WPH < 1 || T_ACC < 1) begin : g_bad_timing
         $error("flash_cmd_seq: strobe widths must be at least one cycle");
      end
      if (MAX_POLLS < 1) begin : g_bad_polls
         $error("flash_cmd_seq: MAX_POLLS must be positive");
      end
   endgenerate

   sq_state_e      state;
   op_e            op_q;
   logic [AW-1:0]  addr_q;
   logic [7:0]     data_q;
   logic [2:0]     step;
   logic [PCW-1:0] poll_cnt;
   logic           done_q, timeout_q;

   logic [AW-1:0]  tbl_addr;
   logic [7:0]     tbl_data;
   logic           tbl_last;
   logic           eng_idle, eng_done, eng_start, eng_rd;
   logic [7:0]     eng_rdata;
   logic           exp_bit;

   fseq_cmd_table #(.AW(AW), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)) u_tbl (
      .op       (op_q),
      .step     (step),
      .tgt_addr (addr_q),
      .tgt_data (data_q),
      .addr     (tbl_addr),
      .data     (tbl_data),
      .last     (tbl_last)
   );

   assign eng_rd    = (state == SQ_POLL);
   assign eng_start = (state != SQ_IDLE) && eng_idle;
   assign exp_bit   = (op_q == OP_PROG) ? data_q[7] : 1'b1;

   fseq_bus_cycle #(.AW(AW), .T_WP(T_WP), .T_WPH(T_WPH), .T_ACC(T_ACC)) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (eng_start),
      .rd       (eng_rd),
      .addr_i   (eng_rd ? addr_q : tbl_addr),
      .data_i   (tbl_data),
      .idle_o   (eng_idle),
      .done_o   (eng_done),
      .rdata_o  (eng_rdata),
      .f_addr   (f_addr),
      .f_dq_out (f_dq_out),
      .f_dq_oe  (f_dq_oe),
      .f_dq_in  (f_dq_in),
      .f_ce_n   (f_ce_n),
      .f_oe_n   (f_oe_n),
      .f_we_n   (f_we_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         op_q      <= OP_PROG;
         addr_q    <= '0;
         data_q    <= '0;
         step      <= '0;
         poll_cnt  <= '0;
         done_q    <= 1'b0;
         timeout_q <= 1'b0;
      end else begin
         done_q    <= 1'b0;
         timeout_q <= 1'b0;
         case (state)
            SQ_IDLE: if (req_valid && (op_e'(req_op) != OP_NONE)) begin
               op_q     <= op_e'(req_op);
               addr_q   <= req_addr;
               data_q   <= req_data;
               step     <= '0;
               poll_cnt <= '0;
               state    <= SQ_CMD;
            end
            SQ_CMD: if (eng_done) begin
               if (tbl_last) state <= SQ_POLL;
               else          step  <= step + 3'd1;
            end
            SQ_POLL: if (eng_done) begin
               if (eng_rdata[7] == exp_bit) begin
                  done_q <= 1'b1;
                  state  <= SQ_IDLE;
               end else if (poll_cnt == PCW'(MAX_POLLS - 1)) begin
                  timeout_q <= 1'b1;
                  state     <= SQ_IDLE;
               end else begin
                  poll_cnt <= poll_cnt + 1'b1;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign busy    = (state != SQ_IDLE);
   assign done    = done_q;
   assign timeout = timeout_q;
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
   parameter int AW = 19
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          timeout,
   input logic [AW-1:0] f_addr,
   input logic [7:0]    f_dq_out,
   input logic          f_dq_oe,
   input logic          f_ce_n,
   input logic          f_oe_n,
   input logic          f_we_n
);
   a_r4_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !f_we_n |-> (!f_ce_n && f_oe_n && f_dq_oe));

   a_r5_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(f_we_n) |-> ($stable(f_addr) && $stable(f_dq_out)));

   a_r7_read_release: assert property (@(posedge clk) disable iff (!rst_n)
      !f_oe_n |-> (!f_ce_n && f_we_n && !f_dq_oe));

   a_r8_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (!f_oe_n && $past(!f_oe_n)) |-> $stable(f_addr));

   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && timeout));

   a_r12_busy_exit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || timeout));

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind flash_cmd_seq fseq_checker #(.AW(AW)) u_fseq_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .timeout  (timeout),
   .f_addr   (f_addr),
   .f_dq_out (f_dq_out),
   .f_dq_oe  (f_dq_oe),
   .f_ce_n   (f_ce_n),
   .f_oe_n   (f_oe_n),
   .f_we_n   (f_we_n)
);

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
   localparam int AW = 19, T_WP = 3, T_WPH = 2, T_ACC = 3, MAXP = 6;
   localparam int PER = 8;
   localparam int WCYC = T_WP + T_WPH + 2;
   localparam int RCYC = T_ACC + 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0] req_data = '0;
   logic busy, done, timeout, f_dq_oe, f_ce_n, f_oe_n, f_we_n;
   logic [AW-1:0] f_addr;
   logic [7:0] f_dq_out, f_dq_in;

   int tests = 0, fails = 0;

   always #(PER/2) clk = ~clk;

   flash_cmd_seq #(.AW(AW), .T_WP(T_WP), .T_WPH(T_WPH), .T_ACC(T_ACC),
                   .MAX_POLLS(MAXP)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
      .timeout(timeout), .f_addr(f_addr), .f_dq_out(f_dq_out),
      .f_dq_oe(f_dq_oe), .f_dq_in(f_dq_in), .f_ce_n(f_ce_n),
      .f_oe_n(f_oe_n), .f_we_n(f_we_n));

   // flash model: write log, read responses, strobe timing
   logic [AW-1:0] wr_addr [64];
   logic [7:0]    wr_data [64];
   logic [AW-1:0] rd_addr [64];
   int wr_n = 0, rd_n = 0, rd_base = 0, busy_reads = 0;
   int wp_bad = 0, gap_bad = 0, strobe_bad = 0, hold_bad = 0, acc_bad = 0, rdsig_bad = 0;
   logic [7:0] final_byte = 8'hFF;
   logic       exp7 = 1'b1;
   time t_wfall = 0, t_wrise = 0, t_rfall = 0;
   logic [AW-1:0] a_fall;
   logic [7:0]    d_fall;

   always @(negedge f_we_n) if (rst_n) begin
      t_wfall = $time;
      a_fall  = f_addr;
      d_fall  = f_dq_out;
      if (f_ce_n !== 1'b0 || f_oe_n !== 1'b1 || f_dq_oe !== 1'b1) strobe_bad++;
      if (wr_n > 0 && ($time - t_wrise) < T_WPH*PER) gap_bad++;
   end

   always @(posedge f_we_n) if (rst_n) begin
      t_wrise = $time;
      if (($time - t_wfall) != T_WP*PER) wp_bad++;
      if (f_addr !== a_fall || f_dq_out !== d_fall) hold_bad++;
      wr_addr[wr_n % 64] = f_addr;
      wr_data[wr_n % 64] = f_dq_out;
      wr_n++;
   end

   always @(negedge f_oe_n) if (rst_n) begin
      t_rfall = $time;
      if (f_ce_n !== 1'b0 || f_we_n !== 1'b1 || f_dq_oe !== 1'b0) rdsig_bad++;
      rd_addr[rd_n % 64] = f_addr;
      rd_n++;
      f_dq_in = ((rd_n - rd_base) <= busy_reads) ? {~exp7, 7'h15} : final_byte;
   end

   always @(posedge f_oe_n) if (rst_n) begin
      if (($time - t_rfall) != T_ACC*PER) acc_bad++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // issue one request and wait for its end; returns edge count and outcome
   task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [7:0] d, input int nbusy, input bit noise,
                         output int cyc, output bit got_done, output bit got_to);
      rd_base    = rd_n;
      busy_reads = nbusy;
      exp7       = (op == 2'd0) ? d[7] : 1'b1;
      final_byte = (op == 2'd0) ? d : 8'hFF;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
      @(posedge clk);
      cyc = 0;
      @(negedge clk);
      chk(busy === 1'b1, "R12 busy after accept", busy, 1);
      if (noise) begin
         req_op = 2'd2; req_addr = '1; req_data = 8'h00;
         repeat (10) @(negedge clk);
         cyc = 10;
      end
      req_valid = 1'b0;
      forever begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (done || timeout || cyc > 5000) break;
      end
      got_done = done;
      got_to   = timeout;
      chk(busy === 1'b0, "R12 busy low at end", busy, 0);
      @(negedge clk);
      chk(done === 1'b0 && timeout === 1'b0, "R9 pulse one cycle", {done, timeout}, 0);
   endtask

   task automatic check_writes(input string req, input int base, input int n,
                               input logic [AW-1:0] ea [6], input logic [7:0] ed [6]);
      chk(wr_n - base == n, {req, " write count"}, wr_n - base, n);
      for (int i = 0; i < n; i++) begin
         chk(wr_addr[(base+i)%64] == ea[i] && wr_data[(base+i)%64] == ed[i],
             {req, " write"}, {wr_addr[(base+i)%64], wr_data[(base+i)%64]},
             {ea[i], ed[i]});
      end
   endtask

   task automatic check_reads(input int base, input int n, input logic [AW-1:0] a);
      chk(rd_n - base == n, "R9 R10 poll count", rd_n - base, n);
      for (int i = 0; i < n; i++)
         chk(rd_addr[(base+i)%64] == a, "R8 poll address", rd_addr[(base+i)%64], a);
   endtask

   task automatic t_reset;
      chk(busy === 0 && done === 0 && timeout === 0, "R12 reset outputs",
          {busy, done, timeout}, 0);
      chk(f_ce_n === 1 && f_oe_n === 1 && f_we_n === 1 && f_dq_oe === 0,
          "R4 reset strobes idle", {f_ce_n, f_oe_n, f_we_n, f_dq_oe}, 4'b1110);
   endtask

   task automatic t_program(input logic [AW-1:0] a, input logic [7:0] d, input int nb,
                            input bit noise);
      int cyc, wb, rb; bit gd, gt;
      logic [AW-1:0] ea [6]; logic [7:0] ed [6];
      ea = '{19'h555, 19'hAAA, 19'h555, a, 0, 0};
      ed = '{8'hAA, 8'h55, 8'hA0, d, 0, 0};
      wb = wr_n; rb = rd_n;
      run_op(2'd0, a, d, nb, noise, cyc, gd, gt);
      check_writes("R1", wb, 4, ea, ed);
      check_reads(rb, nb + 1, a);
      chk(gd && !gt, "R9 program done", {gd, gt}, 2'b10);
      if (!noise)
         chk(cyc == 4*WCYC + (nb+1)*RCYC, "R13 program latency", cyc, 4*WCYC + (nb+1)*RCYC);
      if (noise) begin
         repeat (20) @(negedge clk);
         chk(wr_n - wb == 4 && busy === 0, "R12 request during busy ignored", wr_n - wb, 4);
      end
   endtask

   task automatic t_erase(input logic [1:0] op, input logic [AW-1:0] a, input int nb);
      int cyc, wb, rb; bit gd, gt;
      logic [AW-1:0] ea [6]; logic [7:0] ed [6];
      ea = '{19'h555, 19'hAAA, 19'h555, 19'h555, 19'hAAA, (op == 2'd1) ? a : 19'h555};
      ed = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, (op == 2'd1) ? 8'h30 : 8'h10};
      wb = wr_n; rb = rd_n;
      run_op(op, a, 8'h00, nb, 1'b0, cyc, gd, gt);
      check_writes((op == 2'd1) ? "R2" : "R3", wb, 6, ea, ed);
      check_reads(rb, nb + 1, a);
      chk(gd && !gt, "R10 erase done", {gd, gt}, 2'b10);
      chk(cyc == 6*WCYC + (nb+1)*RCYC, "R13 erase latency", cyc, 6*WCYC + (nb+1)*RCYC);
   endtask

   task automatic t_timeout;
      int cyc, rb; bit gd, gt;
      rb = rd_n;
      run_op(2'd1, 19'h3_0000, 8'h00, 1000, 1'b0, cyc, gd, gt);
      chk(gt && !gd, "R11 timeout flag", {gd, gt}, 2'b01);
      chk(rd_n - rb == MAXP, "R11 poll limit", rd_n - rb, MAXP);
      chk(cyc == 6*WCYC + MAXP*RCYC, "R11 timeout latency", cyc, 6*WCYC + MAXP*RCYC);
   endtask

   task automatic t_bad_op;
      int wb;
      wb = wr_n;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'd3; req_addr = 19'h1_2345;
      @(negedge clk);
      chk(busy === 1'b0, "R12 op 3 ignored busy", busy, 0);
      req_valid = 1'b0;
      repeat (10) @(negedge clk);
      chk(wr_n == wb && busy === 1'b0, "R12 op 3 no writes", wr_n - wb, 0);
   endtask

   initial begin
      #(PER * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program(19'h4_1234, 8'hC3, 3, 1'b0);
      t_program(19'h0_0777, 8'h5A, 0, 1'b0);
      t_erase(2'd1, 19'h7_0000, 5);
      t_erase(2'd2, 19'h0_1000, 2);
      t_timeout();
      t_program(19'h2_0001, 8'h81, 2, 1'b1);
      t_bad_op();
      chk(strobe_bad == 0, "R4 write strobe qualifiers", strobe_bad, 0);
      chk(hold_bad == 0, "R5 hold at write rise", hold_bad, 0);
      chk(wp_bad == 0, "R6 write pulse width", wp_bad, 0);
      chk(gap_bad == 0, "R6 write high gap", gap_bad, 0);
      chk(acc_bad == 0, "R7 read access width", acc_bad, 0);
      chk(rdsig_bad == 0, "R7 read strobe qualifiers", rdsig_bad, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule